// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

This block is a true dual-port synchronous static memory. Two ports, A and B, each with its own clock, can each read or write any word at any time, including the same word in the same cycle. Every port registers its address, controls and write data on the rising edge of its clock. A per-port latency select chooses one of two read paths. In the flow-through path, read data follows the registered address within the same cycle. In the pipelined path, read data goes through one more output register.

Each port takes its access address from an internal burst counter. That counter can be loaded from the address pins, advanced by one, held or cleared, so a port can stream through consecutive words without presenting new addresses. Two chip selects of opposite polarity gate each port's access. A deselected port forces its read output to zero, which stands in for a tri-stated bus. The parameters set the word width and the address width. The typical build is 13 address bits by 9 data bits. The default is smaller so that elaboration stays light.

The same-cycle collision rules assume both clocks share edges. Storage is a pair of banks, one written only by each port. The stored word is the XOR of the two banks, so each bank has exactly one writing clock domain.

Top module: `dpr_sync_ram`

## Requirements
- R1: Both ports perform independent reads and writes in the same cycle at any pair of addresses, and each returns the word stored at its own address.
- R2: The port captures its address, controls and write data on its clock's rising edge. A write becomes visible to any read that is registered on a later edge.
- R3: With the latency select low (flow-through), a read registered on edge k drives its word on the read output from edge k until edge k+1.
- R4: With the latency select high (pipelined), the same read drives its word one cycle later, from edge k+1 until edge k+2.
- R5: A cycle in which the active-low select is high or the active-high select is low is deselected. That cycle performs no write, and it yields zero on the read output in its output slot.
- R6: In pipelined mode, after a deselected cycle the read output stays zero through the first enabled cycle. Data returns only for a read registered on the next enabled edge or later.
- R7: The access address register loads with these priorities. Clear sets it to zero, which takes priority over load. Load copies the address pins. Otherwise step adds one, wrapping from the top word to zero, and with none of these the address holds. These updates happen whether or not the port is selected.
- R8: When both ports write the same address in the same cycle, port A's data is stored.
- R9: When one port reads an address that the other port writes in the same cycle, the read returns the word held before that write.
- R10: While reset (active low) is asserted, both read outputs are zero and both address registers are zero.
- R11: A selected cycle with the active-low write strobe low performs a write and yields zero on that port's read output in its output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of registers (not of stored words) |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_pipe | input | 1 | Port A latency select: 0 flow-through, 1 pipelined |
| a_load | input | 1 | Port A: load address register from a_addr |
| a_step | input | 1 | Port A: advance address register by one |
| a_clr | input | 1 | Port A: clear address register |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not driving |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_pipe | input | 1 | Port B latency select: 0 flow-through, 1 pipelined |
| b_load | input | 1 | Port B: load address register from b_addr |
| b_step | input | 1 | Port B: advance address register by one |
| b_clr | input | 1 | Port B: clear address register |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not driving |

## Verification
A burst fill writes every word through the stepping address, then wraps to word zero. This separates a counter that wraps from one that saturates or skips. Directed pairs aim both ports at one address, once as write against write and once as write against read. These pairs tell port A's priority and old-data reads apart from a merged or reordered commit. Randomized cycles then mix selects, strobes, latency changes, loads, steps and clears over a narrow address window, so collisions are frequent. Each output is compared every cycle against a bench model. That comparison shows up a latency off by one, a lost deselect and a counter priority error as distinct mismatches.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NPORTS = 2;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   cs_i,
  input  logic                   wr_ni,
  input  logic                   pipe_i,
  input  logic                   load_i,
  input  logic                   step_i,
  input  logic                   clr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [ADDR_W-1:0]      acc_addr_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   wr_o,
  output logic                   rd_o,
  output dpr_pkg::lat_mode_e     mode_o
);
  logic sel;
  assign sel = !cs_ni && cs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_addr_o <= '0;
      wdata_o    <= '0;
      wr_o       <= 1'b0;
      rd_o       <= 1'b0;
      mode_o     <= dpr_pkg::LAT_FLOW;
    end else begin
      wr_o    <= sel && !wr_ni;
      rd_o    <= sel && wr_ni;
      wdata_o <= wdata_i;
      mode_o  <= pipe_i ? dpr_pkg::LAT_PIPE : dpr_pkg::LAT_FLOW;
      // address source priority: clear, then load, then step, else hold
      if (clr_i)       acc_addr_o <= '0;
      else if (load_i) acc_addr_o <= addr_i;
      else if (step_i) acc_addr_o <= acc_addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr0_i,
  input  logic [ADDR_W-1:0] raddr1_i,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // both banks start equal so their XOR is a defined zero word
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata0_o = cells[raddr0_i];
  assign rdata1_o = cells[raddr1_i];
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int unsigned DATA_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  dpr_pkg::lat_mode_e mode_i,
  input  logic [DATA_W-1:0]  word_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] flow_word;
  logic [DATA_W-1:0] pipe_q;

  assign flow_word = rd_i ? word_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= flow_word;
  end

  assign rdata_o = (mode_i == dpr_pkg::LAT_PIPE) ? pipe_q : flow_word;
endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_wr_n,
  input  logic              a_pipe,
  input  logic              a_load,
  input  logic              a_step,
  input  logic              a_clr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_wr_n,
  input  logic              b_pipe,
  input  logic              b_load,
  input  logic              b_step,
  input  logic              b_clr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned NP = dpr_pkg::NPORTS;

  logic [NP-1:0]     clk_v, cs_n_v, cs_v, wr_n_v, pipe_v, load_v, step_v, clr_v;
  logic [ADDR_W-1:0] addr_v   [NP];
  logic [DATA_W-1:0] wdata_v  [NP];
  logic [DATA_W-1:0] rdata_v  [NP];

  logic [ADDR_W-1:0] acc_addr [NP];
  logic [DATA_W-1:0] wdata_q  [NP];
  logic [NP-1:0]     wr_q, rd_q, commit;
  dpr_pkg::lat_mode_e mode_q  [NP];

  // bank_rd[bank][port]: bank contents at that port's access address
  logic [DATA_W-1:0] bank_rd  [NP][NP];
  logic [DATA_W-1:0] word     [NP];

  assign clk_v  = {clk_b,  clk_a};
  assign cs_n_v = {b_cs_n, a_cs_n};
  assign cs_v   = {b_cs,   a_cs};
  assign wr_n_v = {b_wr_n, a_wr_n};
  assign pipe_v = {b_pipe, a_pipe};
  assign load_v = {b_load, a_load};
  assign step_v = {b_step, a_step};
  assign clr_v  = {b_clr,  a_clr};
  assign addr_v[0]  = a_addr;
  assign addr_v[1]  = b_addr;
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

  // port A always commits; port B yields on a same-address collision
  assign commit[0] = wr_q[0];
  assign commit[1] = wr_q[1] && !(wr_q[0] && (acc_addr[0] == acc_addr[1]));

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) front_i (
      .clk_i      (clk_v[p]),
      .rst_ni     (rst_n),
      .cs_ni      (cs_n_v[p]),
      .cs_i       (cs_v[p]),
      .wr_ni      (wr_n_v[p]),
      .pipe_i     (pipe_v[p]),
      .load_i     (load_v[p]),
      .step_i     (step_v[p]),
      .clr_i      (clr_v[p]),
      .addr_i     (addr_v[p]),
      .wdata_i    (wdata_v[p]),
      .acc_addr_o (acc_addr[p]),
      .wdata_o    (wdata_q[p]),
      .wr_o       (wr_q[p]),
      .rd_o       (rd_q[p]),
      .mode_o     (mode_q[p])
    );

    // bank p stores the written word XOR the other bank's word there
    dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
      .clk_i    (clk_v[p]),
      .we_i     (commit[p]),
      .waddr_i  (acc_addr[p]),
      .wdata_i  (wdata_q[p] ^ bank_rd[NP-1-p][p]),
      .raddr0_i (acc_addr[0]),
      .raddr1_i (acc_addr[1]),
      .rdata0_o (bank_rd[p][0]),
      .rdata1_o (bank_rd[p][1])
    );

    assign word[p] = bank_rd[0][p] ^ bank_rd[1][p];

    dpr_out_stage #(.DATA_W(DATA_W)) out_i (
      .clk_i   (clk_v[p]),
      .rst_ni  (rst_n),
      .rd_i    (rd_q[p]),
      .mode_i  (mode_q[p]),
      .word_i  (word[p]),
      .rdata_o (rdata_v[p])
    );
  end
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_cs_n,
  input logic              a_cs,
  input logic              a_wr_n,
  input logic              a_pipe,
  input logic              a_load,
  input logic              a_clr,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_cs_n,
  input logic              b_cs,
  input logic              b_pipe,
  input logic [DATA_W-1:0] b_rdata,
  input logic [ADDR_W-1:0] a_acc
);
  p_desel_zero_a_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    ((a_cs_n || !a_cs) && !a_pipe) |=> (a_rdata == '0));

  p_desel_zero_b_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    ((b_cs_n || !b_cs) && !b_pipe) |=> (b_rdata == '0));

  p_write_quiet_r11: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_cs_n && a_cs && !a_wr_n && !a_pipe) |=> (a_rdata == '0));

  p_pipe_gap_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_pipe && $past(a_pipe) && $past(a_cs_n || !a_cs)) |=> (a_rdata == '0));

  p_addr_clear_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_clr |=> (a_acc == '0));

  p_addr_load_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_load && !a_clr) |=> (a_acc == $past(a_addr)));

  p_reset_quiet_r10: assert property (@(posedge clk_a)
    !rst_n |-> (a_rdata == '0 && b_rdata == '0 && a_acc == '0));
endmodule

bind dpr_sync_ram dpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .rst_n   (rst_n),
  .a_cs_n  (a_cs_n),
  .a_cs    (a_cs),
  .a_wr_n  (a_wr_n),
  .a_pipe  (a_pipe),
  .a_load  (a_load),
  .a_clr   (a_clr),
  .a_addr  (a_addr),
  .a_rdata (a_rdata),
  .b_cs_n  (b_cs_n),
  .b_cs    (b_cs),
  .b_pipe  (b_pipe),
  .b_rdata (b_rdata),
  .a_acc   (acc_addr[0])
);

// File: tb/dpr_sync_ram_tb.sv
module dpr_sync_ram_tb_top;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n [2], cs [2], wr_n [2], pipe [2], load [2], step [2], clr [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd_a, rd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] mem [DEPTH];
  logic m_rd [2], m_wr [2], m_lat [2];
  logic [AW-1:0] m_addr [2];
  logic [DW-1:0] m_wd [2], m_pipe [2];

  always #10 clk = ~clk;

  dpr_sync_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .a_cs_n(cs_n[0]), .a_cs(cs[0]), .a_wr_n(wr_n[0]), .a_pipe(pipe[0]),
    .a_load(load[0]), .a_step(step[0]), .a_clr(clr[0]),
    .a_addr(addr[0]), .a_wdata(wd[0]), .a_rdata(rd_a),
    .b_cs_n(cs_n[1]), .b_cs(cs[1]), .b_wr_n(wr_n[1]), .b_pipe(pipe[1]),
    .b_load(load[1]), .b_step(step[1]), .b_clr(clr[1]),
    .b_addr(addr[1]), .b_wdata(wd[1]), .b_rdata(rd_b)
  );

  function automatic logic [DW-1:0] expect_out(input int p);
    if (m_lat[p]) return m_pipe[p];
    return m_rd[p] ? mem[m_addr[p]] : '0;
  endfunction

  task automatic check(input string tag, input int p, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %0d: got %h expected %h", tag, p, got, exp);
    end
  endtask

  task automatic set_port(input int p, input logic s_n, input logic s, input logic w_n,
                          input logic pl, input logic ld, input logic st, input logic cl,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_n[p] = s_n; cs[p] = s; wr_n[p] = w_n; pipe[p] = pl;
    load[p] = ld; step[p] = st; clr[p] = cl; addr[p] = a; wd[p] = d;
  endtask

  task automatic idle(input int p);
    set_port(p, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  // apply current inputs for one edge, update the model, check both outputs
  task automatic tick(input string tag);
    logic [DW-1:0] pn [2];
    for (int p = 0; p < 2; p++) pn[p] = m_rd[p] ? mem[m_addr[p]] : '0;
    if (m_wr[1] && !(m_wr[0] && m_addr[0] == m_addr[1])) mem[m_addr[1]] = m_wd[1];
    if (m_wr[0]) mem[m_addr[0]] = m_wd[0];
    for (int p = 0; p < 2; p++) begin
      m_rd[p]   = !cs_n[p] && cs[p] && wr_n[p];
      m_wr[p]   = !cs_n[p] && cs[p] && !wr_n[p];
      m_lat[p]  = pipe[p];
      m_wd[p]   = wd[p];
      m_pipe[p] = pn[p];
      if (clr[p])       m_addr[p] = '0;
      else if (load[p]) m_addr[p] = addr[p];
      else if (step[p]) m_addr[p] = m_addr[p] + 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, 0, rd_a, expect_out(0));
    check(tag, 1, rd_b, expect_out(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      m_rd[p] = 0; m_wr[p] = 0; m_lat[p] = 0; m_addr[p] = '0; m_wd[p] = '0; m_pipe[p] = '0;
      idle(p);
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: quiet outputs in reset
    check("R10", 0, rd_a, '0);
    check("R10", 1, rd_b, '0);
    rst_n = 1'b1;
    // R10: address register starts at zero: read without load hits word 0
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd99, '0);
    tick("R10");

    // R7: burst fill of every word through the stepping address
    set_port(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, DW'(5));
    tick("R7");
    for (int i = 1; i < DEPTH; i++) begin
      set_port(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, DW'(i * 37 + 5));
      tick("R11");
    end
    // R7: one more step wraps to word 0, then a few stepped reads
    for (int i = 0; i < 4; i++) begin
      set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
      tick("R7");
    end
    // R7: clear beats load
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd77, '0);
    tick("R7");
    // R7: hold with no control
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd77, '0);
    tick("R7");

    // R3: flow-through read
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, '0);
    tick("R3");
    // R4: pipelined reads, data one cycle later
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd6, '0);
    tick("R4");
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
    tick("R4");
    tick("R4");

    // R1: both ports read different words together
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd20, '0);
    set_port(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd21, '0);
    tick("R1");

    // R8: same-address writes, A wins; then both read it
    set_port(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd9, 9'h0aa);
    set_port(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd9, 9'h155);
    tick("R8");
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd9, '0);
    set_port(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd9, '0);
    tick("R8");
    tick("R8");
    checks++;
    if (rd_a !== 9'h0aa) begin
      errors++;
      $display("FAIL R8 direct: got %h expected %h", rd_a, 9'h0aa);
    end

    // R9: A writes word 12 while B reads it: B sees old value; R2: next read sees new
    set_port(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd12, 9'h1c3);
    set_port(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd12, '0);
    tick("R9");
    idle(0);
    tick("R2");

    // R5: deselected write attempts (each select separately) do not store
    set_port(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd3, 9'h1ff);
    tick("R5");
    set_port(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd3, 9'h1fe);
    tick("R5");
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd3, '0);
    tick("R5");
    idle(1);

    // R6: pipelined deselect then re-enable
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd30, '0);
    tick("R6");
    tick("R6");
    set_port(0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd30, '0);
    tick("R6");
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd30, '0);
    tick("R6");
    tick("R6");

    // R11: flow-through write cycle on port B yields zero
    set_port(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd40, 9'h033);
    tick("R11");

    // R1: random mixed traffic over a narrow window
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        set_port(p, ($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2,
                 ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0,
                 ($urandom % 32) == 0, AW'($urandom % 6), DW'($urandom));
      end
      tick("R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule